// File: doc/BRIEF.md
# Two-Wire Host Port Slave

This block is the slave end of a narrow host port. Command, address and data share a two-bit bidirectional bus, and a single shared control line frames each transfer. Everything is sampled on the host clock, which runs at 25 to 33 MHz. The block deserializes a command byte and a register address. It then answers in a dedicated retry cycle, either accepting the transfer or stopping it. After one turnaround cycle it moves a single data byte to or from a small register file while it acknowledges on the control line.

Every tri-state output has its own output enable. The surrounding pad logic resolves the shared lines, and the control line idles high through a pull-up when nobody drives it. An interrupt request line, active low, is driven from a request input. A configuration register inside the map chooses between open-drain and push-pull drive for that line. The same register also holds a bit that makes the slave stop every transfer to any other address.

Top module: `twohp_slave`

## Requirements
- R1: After reset all output enables (`had_oe_o`, `ctl_oe_o`) are low, every register reads 0, and with the request input inactive the interrupt line is released.
- R2: A transfer starts in the first cycle in which the slave is idle and samples the control line high. Bytes move as four bus pairs, bits 7:6 first and 1:0 last. Four cycles carry the command byte, then four carry the address byte, then one decode cycle, one retry cycle and one turnaround cycle follow. Bit 7 of the command selects the direction: 1 is read, 0 is write. The other command bits are ignored.
- R3: For a mapped address that is not stopped, the slave drives the control line high in the retry cycle only. During the decode and turnaround cycles it drives neither the control line nor the data bus.
- R4: In each of the four data cycles the slave drives the control line high as an acknowledge.
- R5: On a read, the slave drives the data bus only during the four data cycles, with the addressed register's bits 7:6, 5:4, 3:2 and 1:0 in that order.
- R6: On a write, the four pairs sampled in the data cycles form the byte written to the addressed register, and a later read returns it.
- R7: The mapped addresses are 0xC0 to 0xC7. For any other address the slave drives neither line in any cycle of the transfer, and no register changes.
- R8: When bit 7 of the configuration register at 0xC2 is 1, a transfer to any other mapped address is stopped. The slave drives the control line low in the retry cycle, and no data phase follows: it drives nothing afterwards, and a write does not land. Transfers to 0xC2 are still served.
- R9: After the fourth data cycle the slave releases both lines. It ignores further pairs and a control line held high until the master has pulled the line low again. Only then can a new transfer start.
- R10: The request input `irq_req_i` is active high and the line is active low. With bit 0 of 0xC2 at 0 (open-drain), `irq_oe_o` equals the request and `irq_o` is 0. With bit 0 at 1 (push-pull), `irq_oe_o` is 1 and `irq_o` is the inverse of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| had_i | input | 2 | Resolved level of the two-bit address/data bus |
| had_o | output | 2 | Data pair driven by the slave |
| had_oe_o | output | 1 | Output enable for `had_o` |
| ctl_i | input | 1 | Resolved level of the shared control line |
| ctl_o | output | 1 | Level driven on the control line (high acknowledge, low stop) |
| ctl_oe_o | output | 1 | Output enable for `ctl_o` |
| irq_req_i | input | 1 | Interrupt request from the logic behind the registers, active high |
| irq_o | output | 1 | Interrupt line level, active low |
| irq_oe_o | output | 1 | Output enable for the interrupt line |

## Verification
The assertions assume a well-behaved master. It holds the control line low while idle, keeps it high through the command and address bytes, and drives it low again only after the slave's retry answer or data phase. They also take the resolved control line to read high whenever no agent drives it. The bench drives the master side one cycle at a time from a single task that follows this phase schedule exactly. It models the pull-up when both sides are released and never drives a line in a cycle in which the slave is expected to drive it.

// File: rtl/twohp_pkg.sv
package twohp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DECODE, S_RETRY, S_TURN, S_DATA, S_WAIT
  } phase_e;
  localparam int PAIR_W     = 2;
  localparam int BYTE_W     = 8;
  localparam int PAIRS_BYTE = BYTE_W / PAIR_W;
endpackage

// File: rtl/twohp_regfile.sv
module twohp_regfile #(
  parameter logic [7:0] REG_BASE = 8'hC0,
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] CFG_ADDR = 8'hC2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       hit_o,
  output logic       stall_o,
  output logic       pushpull_o
);
  localparam int         IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] MAP_END = 9'(REG_BASE) + 9'(NUM_REGS);
  localparam logic [7:0] CFG_OFS = CFG_ADDR - REG_BASE;
  localparam int         CFG_IDX = int'(CFG_OFS);

  logic [7:0]       regs [NUM_REGS];
  logic [7:0]       offs;
  logic [IDX_W-1:0] idx;

  assign offs  = addr_i - REG_BASE;
  assign idx   = offs[IDX_W-1:0];
  assign hit_o = (addr_i >= REG_BASE) && ({1'b0, addr_i} < MAP_END);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs[g] <= '0;
      else if (we_i && hit_o && idx == IDX_W'(g))   regs[g] <= wdata_i;
    end
  end

  assign rdata_o    = regs[idx];
  assign pushpull_o = regs[CFG_IDX][0];
  // hold bit stops every mapped transfer except to the config register itself
  assign stall_o    = regs[CFG_IDX][7] && (addr_i != CFG_ADDR);

  p_we_mapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> hit_o && !stall_o);
endmodule

// File: rtl/twohp_fsm.sv
module twohp_fsm
  import twohp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] had_i,
  input  logic       ctl_i,
  input  logic [7:0] rdata_i,
  input  logic       hit_i,
  input  logic       stall_i,
  output logic [7:0] addr_o,
  output logic       we_o,
  output logic [7:0] wdata_o,
  output logic [1:0] had_o,
  output logic       had_oe_o,
  output logic       ctl_o,
  output logic       ctl_oe_o
);
  localparam logic [1:0] LAST = 2'(PAIRS_BYTE - 1);

  phase_e     state_q;
  logic [1:0] cnt_q;
  logic [7:0] sh_q;
  logic [7:0] nxt_byte;
  logic       rd_q, hit_q, stop_q;
  logic [7:0] addr_q;

  assign nxt_byte = {sh_q[5:0], had_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      hit_q   <= 1'b0;
      stop_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (ctl_i) begin
          sh_q    <= {6'd0, had_i};
          cnt_q   <= 2'd1;
          state_q <= S_CMD;
        end
        S_CMD: begin
          sh_q  <= nxt_byte;
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == LAST) begin
            rd_q    <= nxt_byte[7];
            state_q <= S_ADDR;
          end
        end
        S_ADDR: begin
          sh_q  <= nxt_byte;
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == LAST) begin
            addr_q  <= nxt_byte;
            state_q <= S_DECODE;
          end
        end
        S_DECODE: begin
          hit_q   <= hit_i;
          stop_q  <= hit_i && stall_i;
          state_q <= S_RETRY;
        end
        S_RETRY: state_q <= (hit_q && !stop_q) ? S_TURN : S_WAIT;
        S_TURN: begin
          if (rd_q) sh_q <= rdata_i;
          cnt_q   <= '0;
          state_q <= S_DATA;
        end
        S_DATA: begin
          sh_q  <= rd_q ? {sh_q[5:0], 2'b00} : nxt_byte;
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == LAST) state_q <= S_WAIT;
        end
        S_WAIT: if (!ctl_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl_oe_o = 1'b0;
    ctl_o    = 1'b0;
    had_oe_o = 1'b0;
    had_o    = '0;
    if (state_q == S_RETRY && hit_q) begin
      ctl_oe_o = 1'b1;
      ctl_o    = !stop_q;
    end
    if (state_q == S_DATA) begin
      ctl_oe_o = 1'b1;
      ctl_o    = 1'b1;
      if (rd_q) begin
        had_oe_o = 1'b1;
        had_o    = sh_q[7:6];
      end
    end
  end

  assign addr_o  = addr_q;
  assign we_o    = (state_q == S_DATA) && (cnt_q == LAST) && !rd_q;
  assign wdata_o = nxt_byte;

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && !ctl_o) |=> (!ctl_oe_o && !had_oe_o));
  p_go_turn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RETRY && ctl_oe_o && ctl_o) |=> (!ctl_oe_o && !had_oe_o));
  p_turn_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TURN) |=> (ctl_oe_o && ctl_o));
  p_read_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    had_oe_o |-> (ctl_oe_o && ctl_o && rd_q));
  p_byte_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && cnt_q == LAST) |=> (!ctl_oe_o && !had_oe_o));
  p_wait_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && ctl_i) |=> (!ctl_oe_o && !had_oe_o));
endmodule

// File: rtl/twohp_irq.sv
module twohp_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pushpull_i,
  input  logic req_i,
  output logic irq_o,
  output logic irq_oe_o
);
  // line is active low in both drive modes
  assign irq_oe_o = pushpull_i ? 1'b1 : req_i;
  assign irq_o    = pushpull_i ? !req_i : 1'b0;

  p_pp_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pushpull_i |-> irq_oe_o);
  p_od_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pushpull_i && irq_oe_o) |-> !irq_o);
endmodule

// File: rtl/twohp_slave.sv
module twohp_slave #(
  parameter logic [7:0] REG_BASE = 8'hC0,
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] CFG_ADDR = 8'hC2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] had_i,
  output logic [1:0] had_o,
  output logic       had_oe_o,
  input  logic       ctl_i,
  output logic       ctl_o,
  output logic       ctl_oe_o,
  input  logic       irq_req_i,
  output logic       irq_o,
  output logic       irq_oe_o
);
  logic [7:0] addr, wdata, rdata;
  logic       we, hit, stall, pushpull;

  twohp_fsm u_fsm (
    .clk_i, .rst_ni, .had_i, .ctl_i,
    .rdata_i(rdata), .hit_i(hit), .stall_i(stall),
    .addr_o(addr), .we_o(we), .wdata_o(wdata),
    .had_o, .had_oe_o, .ctl_o, .ctl_oe_o
  );

  twohp_regfile #(.REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk_i, .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .hit_o(hit), .stall_o(stall), .pushpull_o(pushpull)
  );

  twohp_irq u_irq (
    .clk_i, .rst_ni, .pushpull_i(pushpull), .req_i(irq_req_i),
    .irq_o, .irq_oe_o
  );

  p_resp_mapped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && !had_oe_o && !$past(ctl_oe_o)) |-> hit);
endmodule

// File: tb/twohp_slave_tb.sv
module twohp_slave_tb;
  localparam time CLK_P = 10ns;

  typedef struct packed {
    logic       ctl_oe;
    logic       ctl;
    logic       had_oe;
    logic [1:0] had;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_ctl_oe = 1'b1, m_ctl = 1'b0;
  logic m_had_oe = 1'b1;
  logic [1:0] m_had = 2'b00;
  logic irq_req = 1'b0;
  logic [1:0] had_o, had_bus;
  logic had_oe_o, ctl_o, ctl_oe_o, ctl_bus, irq_o, irq_oe_o;

  int checks = 0, errors = 0;
  logic [7:0] model [8];
  exp_t  exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  // pad resolution: slave, then master, else pull-up high
  assign ctl_bus = ctl_oe_o ? ctl_o : (m_ctl_oe ? m_ctl : 1'b1);
  assign had_bus = had_oe_o ? had_o : (m_had_oe ? m_had : 2'b11);

  twohp_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .had_i(had_bus), .had_o(had_o), .had_oe_o(had_oe_o),
    .ctl_i(ctl_bus), .ctl_o(ctl_o), .ctl_oe_o(ctl_oe_o),
    .irq_req_i(irq_req), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compares one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      logic [4:0] a, x;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {ctl_oe_o, ctl_oe_o & ctl_o, had_oe_o, had_oe_o ? had_o : 2'b00};
      x = {e.ctl_oe, e.ctl_oe & e.ctl, e.had_oe, e.had_oe ? e.had : 2'b00};
      check(t, a, x);
    end
  end

  task automatic cyc(input logic mco, input logic mc, input logic mho, input logic [1:0] mh,
                     input exp_t e, input string tag);
    @(posedge clk);
    #1;
    m_ctl_oe = mco; m_ctl = mc; m_had_oe = mho; m_had = mh;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  localparam exp_t QUIET = '{1'b0, 1'b0, 1'b0, 2'b00};

  task automatic xfer(input bit rd, input logic [7:0] addr, input logic [7:0] wd,
                      input bit extra, input string tag);
    logic [7:0] cmd;
    bit hit, stall;
    int idx;
    exp_t e;
    cmd   = {rd, 7'h35};
    hit   = (addr >= 8'hC0) && (addr <= 8'hC7);
    idx   = int'(addr[2:0]);
    stall = hit && model[2][7] && (addr != 8'hC2);
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, cmd[7-2*i -: 2], QUIET, {tag, " R2 cmd"});
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, addr[7-2*i -: 2], QUIET, {tag, " R2 addr"});
    cyc(0, 0, !rd, 2'b00, QUIET, {tag, " R3 decode"});
    if (!hit) begin
      cyc(0, 0, !rd, 2'b00, QUIET, {tag, " R7 retry"});
      cyc(1, 0, 1, 2'b00, QUIET, {tag, " R7 end"});
    end else if (stall) begin
      e = '{1'b1, 1'b0, 1'b0, 2'b00};
      cyc(0, 0, !rd, 2'b00, e, {tag, " R8 retry stop"});
      cyc(1, 0, 1, 2'b00, QUIET, {tag, " R8 no data"});
    end else begin
      e = '{1'b1, 1'b1, 1'b0, 2'b00};
      cyc(0, 0, !rd, 2'b00, e, {tag, " R3 retry go"});
      cyc(0, 0, !rd, 2'b00, QUIET, {tag, " R3 turn"});
      for (int i = 0; i < 4; i++) begin
        e = '{1'b1, 1'b1, rd, rd ? model[idx][7-2*i -: 2] : 2'b00};
        cyc(0, 0, !rd, wd[7-2*i -: 2], e, {tag, rd ? " R5 data" : " R4 data"});
      end
      if (!rd) model[idx] = wd;
      if (extra)
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, ~wd[7-2*i -: 2], QUIET, {tag, " R9 ignored"});
      cyc(1, 0, 1, 2'b00, QUIET, {tag, " R9 end"});
    end
    cyc(1, 0, 1, 2'b00, QUIET, {tag, " R2 idle"});
  endtask

  task automatic irq_check(input logic req, input logic pp, input string tag);
    @(posedge clk);
    #1 irq_req = req;
    @(negedge clk);
    check(tag, {3'b000, irq_oe_o, irq_o},
          {3'b000, pp ? 1'b1 : req, pp ? !req : 1'b0});
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {had_oe_o, ctl_oe_o, irq_oe_o, 2'b00}, 5'b00000);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    xfer(1, 8'hC0, 8'h00, 0, "R1 read reset");
    xfer(1, 8'hC7, 8'h00, 0, "R1 read reset top");
    xfer(0, 8'hC0, 8'hA5, 0, "R6 write C0");
    xfer(1, 8'hC0, 8'h00, 0, "R6 readback C0");
    xfer(0, 8'hC5, 8'h3C, 0, "R6 write C5");
    xfer(1, 8'hC5, 8'h00, 0, "R5 readback C5");
    xfer(0, 8'h40, 8'h77, 0, "R7 write miss");
    xfer(1, 8'hC8, 8'h00, 0, "R7 read miss");
    xfer(1, 8'hC0, 8'h00, 0, "R7 C0 unchanged");
    xfer(0, 8'hC3, 8'h5A, 1, "R9 write trailing");
    xfer(1, 8'hC3, 8'h00, 0, "R9 readback C3");

    irq_check(1'b0, 1'b0, "R10 od idle");
    irq_check(1'b1, 1'b0, "R10 od active");
    xfer(0, 8'hC2, 8'h81, 0, "R8 set hold pp");
    irq_check(1'b1, 1'b1, "R10 pp active");
    irq_check(1'b0, 1'b1, "R10 pp idle");
    xfer(0, 8'hC1, 8'hFF, 0, "R8 stopped write");
    xfer(1, 8'hC1, 8'h00, 0, "R8 stopped read");
    xfer(1, 8'hC2, 8'h00, 0, "R8 cfg served");
    xfer(0, 8'hC2, 8'h00, 0, "R8 clear hold");
    xfer(1, 8'hC1, 8'h00, 0, "R8 write did not land");
    irq_check(1'b1, 1'b0, "R10 od again");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule